// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block drives the system reset of a processor from three causes: a supply-fault level produced by an external voltage comparator, a manual pushbutton, and a software watchdog. Reset is held for as long as the comparator reports the supply out of tolerance. After the supply recovers, reset is stretched for a fixed hold time. The 5% or 10% tolerance band is chosen at the comparator, outside this block. The pushbutton is debounced, and an accepted press gives a stretched reset. The watchdog forces a reset when a strobe input, normally taken from bus address, data or control activity, shows no rising edge for the watchdog period.

Reset is driven as a complementary pair of registered outputs that switch on the same clock edge. All periods are given in milliseconds and converted to cycles through a clock-rate parameter. The hold time is never shorter than the 25 ms minimum parameter. The watchdog period is limited to the 600 ms ceiling parameter. Every input passes through a two-flop synchronizer. An active-low asynchronous power-on input starts the block with reset asserted and the hold timer loaded.

Below, HOLD = max(HOLD_MS, MIN_MS) * CLK_KHZ, WDOG = min(WDOG_MS, WDOG_MAX_MS) * CLK_KHZ and DEB = DEB_MS * CLK_KHZ, all counted in clock cycles. Edges are rising edges of `clk_i`.

Top module: `reset_supervisor`

## Requirements
- R1: While `por_ni` is 0, `rst_o` is 1 and `rst_no` is 0. With the supply good (`supply_low_i` = 0), `rst_o` falls on the (HOLD+2)-th edge after `por_ni` rises.
- R2: `supply_low_i` = 1 means the supply is out of tolerance. `rst_o` rises on the 3rd edge after `supply_low_i` rises, and it stays 1 for as long as `supply_low_i` stays 1, however long that is.
- R3: After `supply_low_i` falls, `rst_o` falls on the (HOLD+2)-th edge.
- R4: The pushbutton is active low (`button_ni` = 0 means pressed). A press lasting fewer than DEB cycles is ignored: `rst_o` stays 0.
- R5: A press of at least DEB cycles raises `rst_o` on the (DEB+3)-th edge after `button_ni` falls. `rst_o` then stays 1 while the button is held and falls on the (HOLD+3)-th edge after `button_ni` rises.
- R6: With no rising edge on `strobe_i`, `rst_o` rises again on the (WDOG+1)-th edge after the edge that released reset. This watchdog reset lasts exactly HOLD cycles.
- R7: A rising edge on `strobe_i` restarts the watchdog count. A strobe that rises at least once every WDOG-3 cycles keeps `rst_o` at 0 indefinitely.
- R8: Only rising edges count as activity. After a rise of `strobe_i`, `rst_o` rises on the (WDOG+4)-th edge even if `strobe_i` stays 1. A strobe held high from before release gives the same timeout as in R6.
- R9: A request from any source while reset is active restarts the hold. After a repeated supply fault, `rst_o` falls on the (HOLD+2)-th edge after the last fault ends.
- R10: `rst_no` is always the inverse of `rst_o`.
- R11: The watchdog count is held cleared while reset is active. After a reset of any length, the timeout of R6 is measured from release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock |
| por_ni | input | 1 | Asynchronous power-on initialisation, active low |
| supply_low_i | input | 1 | Comparator flag, 1 = supply out of tolerance |
| button_ni | input | 1 | Manual reset pushbutton, 0 = pressed |
| strobe_i | input | 1 | Software activity strobe, rising edge = activity |
| rst_o | output | 1 | System reset, active high |
| rst_no | output | 1 | System reset, active low |

## Verification
Every result has a fixed latency: a supply fault shows 3 edges after the input changes, an accepted press DEB+3 edges after it, a release HOLD+2 edges after a supply recovery and HOLD+3 after a button release, and a watchdog reset WDOG+1 edges after release or WDOG+4 edges after the last strobe rise. The bench drives inputs on falling clock edges and samples `rst_o` on falling edges. It counts the falling edges at which reset holds its level, so each measured interval is compared against an exact count rather than a window. Glitch and keep-alive scenarios watch every cycle of the interval in which reset must not move.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } hold_state_e;

    function automatic int unsigned pick_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned pick_min(input int unsigned a, input int unsigned b);
        return (a < b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        int unsigned w;
        w = $clog2(n + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
    parameter int unsigned      N    = 3,
    parameter logic [N-1:0]     INIT = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = d_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.meta   <= INIT;
            st_q.stable <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.stable;

endmodule

// File: rtl/rsup_debounce.sv
module rsup_debounce #(
    parameter int unsigned DEB_CYC = 5
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pressed_i,
    output logic accepted_o
);

    localparam int unsigned W = rsup_pkg::cnt_width(DEB_CYC);
    localparam logic [W-1:0] LAST = W'(DEB_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         acc;
    } deb_t;

    deb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pressed_i) begin
            st_d.cnt = '0;
            st_d.acc = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.acc = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt <= '0;
            st_q.acc <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign accepted_o = st_q.acc;

    AST_DEB_RELEASE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pressed_i |=> !st_q.acc); // R4

    AST_DEB_HOLDS_WHILE_PRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pressed_i && st_q.acc) |=> st_q.acc); // R5

endmodule

// File: rtl/rsup_watchdog.sv
module rsup_watchdog #(
    parameter int unsigned WD_CYC = 400
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hold_i,
    input  logic strobe_i,
    output logic bite_o
);

    localparam int unsigned W = rsup_pkg::cnt_width(WD_CYC);
    localparam logic [W-1:0] LAST = W'(WD_CYC - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         prev;
        logic         bite;
    } wd_t;

    wd_t  st_d, st_q;
    logic activity;

    assign activity = strobe_i && !st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe_i;
        st_d.bite = 1'b0;
        if (hold_i) begin
            st_d.cnt = '0;
        end else if (activity) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt  = '0;
            st_d.bite = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cnt  <= '0;
            st_q.prev <= 1'b0;
            st_q.bite <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bite_o = st_q.bite;

    AST_WD_CLEAR_IN_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hold_i |=> (st_q.cnt == '0 && !st_q.bite)); // R11

    AST_WD_EDGE_RESTARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && strobe_i && !st_q.prev) |=> (st_q.cnt == '0 && !st_q.bite)); // R7

    AST_WD_LEVEL_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!hold_i && strobe_i && st_q.prev && st_q.cnt != LAST) |=> (st_q.cnt == $past(st_q.cnt) + W'(1))); // R8

endmodule

// File: rtl/rsup_hold.sv
module rsup_hold #(
    parameter int unsigned HOLD_CYC = 100
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic rst_o,
    output logic rst_no
);

    import rsup_pkg::*;

    localparam int unsigned W = cnt_width(HOLD_CYC);
    localparam logic [W-1:0] FULL = W'(HOLD_CYC);

    typedef struct packed {
        hold_state_e  state;
        logic [W-1:0] cnt;
        logic         rst;
        logic         rst_n;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (req_i) begin
            st_d.state = HOLD_ACTIVE;
            st_d.cnt   = FULL;
        end else if (st_q.state == HOLD_ACTIVE) begin
            if (st_q.cnt <= W'(1)) begin
                st_d.state = HOLD_IDLE;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
        st_d.rst   = (st_d.state == HOLD_ACTIVE);
        st_d.rst_n = (st_d.state != HOLD_ACTIVE);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.state <= HOLD_ACTIVE;
            st_q.cnt   <= FULL;
            st_q.rst   <= 1'b1;
            st_q.rst_n <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_o  = st_q.rst;
    assign rst_no = st_q.rst_n;

    AST_OUT_COMPLEMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.rst != st_q.rst_n)); // R10

    AST_REQ_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> st_q.rst); // R2

    AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(st_q.rst) |-> ($past(st_q.cnt) == W'(1) && !$past(req_i))); // R3

    AST_NO_EARLY_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.rst && st_q.cnt > W'(1)) |=> st_q.rst); // R9

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
    parameter int unsigned CLK_KHZ     = 125000,
    parameter int unsigned HOLD_MS     = 100,
    parameter int unsigned MIN_MS      = 25,
    parameter int unsigned WDOG_MS     = 400,
    parameter int unsigned WDOG_MAX_MS = 600,
    parameter int unsigned DEB_MS      = 5
) (
    input  logic clk_i,
    input  logic por_ni,
    input  logic supply_low_i,
    input  logic button_ni,
    input  logic strobe_i,
    output logic rst_o,
    output logic rst_no
);

    import rsup_pkg::*;

    localparam int unsigned HOLD_CYC = pick_max(HOLD_MS, MIN_MS) * CLK_KHZ;
    localparam int unsigned WDOG_CYC = pick_min(WDOG_MS, WDOG_MAX_MS) * CLK_KHZ;
    localparam int unsigned DEB_CYC  = pick_max(DEB_MS * CLK_KHZ, 1);

    localparam int unsigned IDX_SUPPLY = 0;
    localparam int unsigned IDX_BUTTON = 1;
    localparam int unsigned IDX_STROBE = 2;
    localparam int unsigned N_IN       = 3;
    localparam logic [N_IN-1:0] SYNC_INIT = 3'b011;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] sync_in;
    logic            press_ok;
    logic            bite;
    logic            req;
    logic            rst_int;
    logic            rst_n_int;

    assign raw_in[IDX_SUPPLY] = supply_low_i;
    assign raw_in[IDX_BUTTON] = button_ni;
    assign raw_in[IDX_STROBE] = strobe_i;

    rsup_sync #(
        .N    (N_IN),
        .INIT (SYNC_INIT)
    ) i_sync (
        .clk_i  (clk_i),
        .rst_ni (por_ni),
        .d_i    (raw_in),
        .q_o    (sync_in)
    );

    rsup_debounce #(
        .DEB_CYC (DEB_CYC)
    ) i_debounce (
        .clk_i      (clk_i),
        .rst_ni     (por_ni),
        .pressed_i  (!sync_in[IDX_BUTTON]),
        .accepted_o (press_ok)
    );

    rsup_watchdog #(
        .WD_CYC (WDOG_CYC)
    ) i_watchdog (
        .clk_i    (clk_i),
        .rst_ni   (por_ni),
        .hold_i   (rst_int),
        .strobe_i (sync_in[IDX_STROBE]),
        .bite_o   (bite)
    );

    assign req = sync_in[IDX_SUPPLY] | press_ok | bite;

    rsup_hold #(
        .HOLD_CYC (HOLD_CYC)
    ) i_hold (
        .clk_i  (clk_i),
        .rst_ni (por_ni),
        .req_i  (req),
        .rst_o  (rst_int),
        .rst_no (rst_n_int)
    );

    assign rst_o  = rst_int;
    assign rst_no = rst_n_int;

    AST_SUPPLY_KEEPS_RESET: assert property (@(posedge clk_i) disable iff (!por_ni)
        sync_in[IDX_SUPPLY] |=> rst_o); // R2

endmodule

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;

    localparam int unsigned CLK_KHZ = 1;
    localparam int HOLD = 100;
    localparam int WD   = 400;
    localparam int DEB  = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic por_n, supply_low, button_n, strobe_force, kick_en, kick_lvl;
    logic rst, rst_n;
    logic strobe;
    int   checks, errors, cyc, compl_bad, kick_div;

    assign strobe = kick_en ? kick_lvl : strobe_force;

    reset_supervisor #(
        .CLK_KHZ     (CLK_KHZ),
        .HOLD_MS     (100),
        .MIN_MS      (25),
        .WDOG_MS     (400),
        .WDOG_MAX_MS (600),
        .DEB_MS      (5)
    ) i_reset_supervisor (
        .clk_i        (clk),
        .por_ni       (por_n),
        .supply_low_i (supply_low),
        .button_ni    (button_n),
        .strobe_i     (strobe),
        .rst_o        (rst),
        .rst_no       (rst_n)
    );

    always @(negedge clk) begin
        cyc++;
        kick_div++;
        if (kick_div >= 100) begin
            kick_div = 0;
            kick_lvl = ~kick_lvl;
        end
        if (rst_n !== ~rst) compl_bad++;
        if (cyc > 60000) begin
            errors++;
            $display("FAIL bench-timeout: actual %0d cycles, expected under 60000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_while(input logic lvl, output int n);
        n = 0;
        while (rst === lvl && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (rst !== 1'b1 && n < 5000);
    endtask

    task automatic steady(input logic lvl, input int len, input string req);
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (rst !== lvl) bad++;
        end
        check(req, bad, 0);
    endtask

    task automatic t_power_on();
        int n;
        repeat (5) @(negedge clk);
        check("R1 reset state rst", int'(rst), 1);
        check("R1 reset state rst_n", int'(rst_n), 0);
        por_n = 1'b1;
        @(negedge clk);
        count_while(1'b1, n);
        check("R1 power-on hold", n, HOLD + 1);
    endtask

    task automatic t_wd_timeout();
        int n;
        count_while(1'b0, n);
        check("R6 timeout after release", n, WD + 1);
        count_while(1'b1, n);
        check("R6 watchdog reset width", n, HOLD);
    endtask

    task automatic t_strobe_level();
        int n;
        steady(1'b0, 300, "R7 no early timeout");
        strobe_force = 1'b1;
        @(negedge clk);
        count_while(1'b0, n);
        check("R8 timeout from strobe rise", n, WD + 3);
        count_while(1'b1, n);
        check("R6 watchdog reset width", n, HOLD);
        count_while(1'b0, n);
        check("R8 constant level no restart", n, WD + 1);
        count_while(1'b1, n);
        check("R6 watchdog reset width", n, HOLD);
        strobe_force = 1'b0;
    endtask

    task automatic t_keepalive();
        kick_en = 1'b1;
        steady(1'b0, 2000, "R7 keep-alive strobe");
    endtask

    task automatic t_supply();
        int n;
        supply_low = 1'b1;
        wait_rise(n);
        check("R2 fault latency", n, 3);
        steady(1'b1, 500, "R2 held during fault");
        supply_low = 1'b0;
        @(negedge clk);
        count_while(1'b1, n);
        check("R3 recovery hold", n, HOLD + 1);
    endtask

    task automatic t_retrigger();
        int n;
        supply_low = 1'b1;
        repeat (10) @(negedge clk);
        supply_low = 1'b0;
        steady(1'b1, 50, "R9 hold in progress");
        supply_low = 1'b1;
        repeat (5) @(negedge clk);
        supply_low = 1'b0;
        @(negedge clk);
        count_while(1'b1, n);
        check("R9 retriggered hold", n, HOLD + 1);
    endtask

    task automatic t_button();
        int n;
        button_n = 1'b0;
        repeat (DEB - 1) @(negedge clk);
        button_n = 1'b1;
        steady(1'b0, 30, "R4 short press ignored");
        button_n = 1'b0;
        wait_rise(n);
        check("R5 accepted press latency", n, DEB + 3);
        steady(1'b1, 200, "R5 held while pressed");
        kick_en      = 1'b0;
        strobe_force = 1'b0;
        button_n     = 1'b1;
        @(negedge clk);
        count_while(1'b1, n);
        check("R5 button release hold", n, HOLD + 2);
    endtask

    task automatic t_wd_after_long_reset();
        int n;
        count_while(1'b0, n);
        check("R11 timeout measured from release", n, WD + 1);
        count_while(1'b1, n);
        check("R6 watchdog reset width", n, HOLD);
    endtask

    initial begin
        checks = 0; errors = 0; cyc = 0; compl_bad = 0; kick_div = 0;
        por_n = 1'b0; supply_low = 1'b0; button_n = 1'b1;
        strobe_force = 1'b0; kick_en = 1'b0; kick_lvl = 1'b0;
        t_power_on();
        t_wd_timeout();
        t_strobe_level();
        t_keepalive();
        t_supply();
        t_retrigger();
        t_button();
        t_wd_after_long_reset();
        check("R10 complementary outputs", compl_bad, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule